// File: doc/BRIEF.md
# Burst column address generator

This block turns one READ or WRITE command into the column address of every data beat of a DDR SDRAM burst. It holds a 13-bit mode word, written by a mode-register-set strobe that also carries a 2-bit bank-address field. Only the bank-address value 00 selects this register. The burst length and burst type are taken from the stored word. The word is also checked for reserved codes, and a reserved code raises an error flag.

When a command is accepted, the block fixes the starting column and the current burst settings. From the next cycle on it emits one column per clock with a valid strobe. The column bits at and above the burst boundary stay fixed. The low bits step through the aligned block in either wrap-around sequential order or XOR interleaved order, and a last flag marks the final beat. A command offered during the last beat is accepted, so bursts can follow one another with no idle cycle.

Top module: `burst_col_gen`

## Requirements
- R1: After reset the stored word is 0x021 (length code 001, sequential, latency code 010, operating field 0): beat_valid and beat_last are 0, cmd_ready is 1 and mode_err is 0.
- R2: A strobe with mrs_ba equal to 00 stores mrs_addr at the next clock edge. A strobe with any other mrs_ba value leaves the word unchanged, which is seen in the length of later bursts and in mode_err.
- R3: Length code mrs_addr[2:0] gives bursts of 2 beats for 001, 4 for 010 and 8 for 011. beat_last is high on beat BL-1 only, and only while beat_valid is high.
- R4: With type bit mrs_addr[3] = 0 (sequential), beat n carries low bits (start + n) mod BL. Here start is the low log2(BL) bits of cmd_col, and all higher column bits equal cmd_col for the whole burst.
- R5: With type bit 1 (interleaved), beat n carries low bits start XOR n, and the higher bits stay constant as in R4.
- R6: mode_err is 1 while the stored word has a reserved field. The length code is reserved unless it is 001, 010 or 011. Latency bits [6:4] are reserved unless they are 010, 110 or 011. Operating bits [12:7] are reserved unless they are 000000 or 000010. The flag follows a load one cycle after the strobe edge.
- R7: A stored reserved length code produces 2-beat bursts, ordered by the stored type bit.
- R8: cmd_ready is 1 when no burst runs or on the last beat. An accepted command shows beat 0 in the next cycle, so a command taken on a last beat follows with no gap. A command offered while cmd_ready is 0 is ignored.
- R9: Length and type are captured when the command is accepted. A load in the same cycle or during the burst changes only later commands.
- R10: beat_write equals cmd_write of the command that started the burst. Reads and writes use identical ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mrs_valid | input | 1 | Mode register set strobe |
| mrs_ba | input | 2 | Bank-address field of the load; 00 selects this register |
| mrs_addr | input | 13 | Mode word: [2:0] length, [3] type, [6:4] latency, [12:7] operating |
| cmd_valid | input | 1 | READ or WRITE command offered |
| cmd_write | input | 1 | 1 for WRITE, 0 for READ |
| cmd_col | input | COL_W | Starting column |
| cmd_ready | output | 1 | Command is accepted this cycle if cmd_valid |
| beat_valid | output | 1 | A beat column is present |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| beat_write | output | 1 | Direction of the running burst |
| mode_err | output | 1 | Stored word holds a reserved code |

## Verification
Two pairs of events can fall in the same cycle. A mode load can coincide with a command acceptance, and a command can arrive on the last beat of the previous burst. The bench provokes both by driving a load on the acceptance cycle and during a running burst, and by holding cmd_valid high across burst boundaries. A behavioural queue model builds each burst from the word as it stood before the edge. It then compares every column, last flag, ready and error output on each clock, so a load applied too early, or a one-cycle gap between bursts, shows up at once.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    localparam int WORD_W = 13;
    localparam int BA_W   = 2;
    localparam int LOW_W  = 3;   // log2 of the longest burst

    typedef struct packed {
        logic [5:0] opm;   // [12:7]
        logic [2:0] lat;   // [6:4]
        logic       ilv;   // [3]
        logic [2:0] len;   // [2:0]
    } mode_word_t;

    localparam mode_word_t MODE_RESET = '{opm: 6'd0, lat: 3'b010, ilv: 1'b0, len: 3'b001};

    function automatic logic len_ok(input logic [2:0] c);
        return (c == 3'b001) || (c == 3'b010) || (c == 3'b011);
    endfunction

    function automatic logic lat_ok(input logic [2:0] c);
        return (c == 3'b010) || (c == 3'b110) || (c == 3'b011);
    endfunction

    function automatic logic opm_ok(input logic [5:0] c);
        return (c == 6'b000000) || (c == 6'b000010);
    endfunction

    // Index of the final beat; reserved length codes run as two beats
    function automatic logic [LOW_W-1:0] beat_limit(input logic [2:0] c);
        case (c)
            3'b010:  return 3'd3;
            3'b011:  return 3'd7;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_col_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [BA_W-1:0]   ld_ba,
    input  logic [WORD_W-1:0] ld_word,
    output logic [2:0]        len_code,
    output logic              ilv,
    output logic              bad
);
    mode_word_t word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= MODE_RESET;
        else if (ld_valid && (ld_ba == '0))
            word_q <= mode_word_t'(ld_word);
    end

    assign len_code = word_q.len;
    assign ilv      = word_q.ilv;
    assign bad      = !(len_ok(word_q.len) && lat_ok(word_q.lat) && opm_ok(word_q.opm));
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_write,
    input  logic [COL_W-1:0] req_col,
    input  logic [2:0]       len_code,
    input  logic             ilv,
    output logic             ready,
    output logic             active,
    output logic             last,
    output logic [LOW_W-1:0] idx,
    output logic [LOW_W-1:0] lim,
    output logic             ilv_q,
    output logic             write_q,
    output logic [COL_W-1:0] col_q
);
    logic at_end;

    assign at_end = (idx == lim);
    assign last   = active && at_end;
    assign ready  = !active || at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            idx     <= '0;
            lim     <= 3'd1;
            ilv_q   <= 1'b0;
            write_q <= 1'b0;
            col_q   <= '0;
        end else if (req && ready) begin
            active  <= 1'b1;
            idx     <= '0;
            lim     <= beat_limit(len_code);
            ilv_q   <= ilv;
            write_q <= req_write;
            col_q   <= req_col;
        end else if (active) begin
            if (at_end)
                active <= 1'b0;
            else
                idx <= idx + 3'd1;
        end
    end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base,
    input  logic [LOW_W-1:0] idx,
    input  logic [LOW_W-1:0] lim,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [LOW_W-1:0] start;
    logic [LOW_W-1:0] step;

    assign start = base[LOW_W-1:0];
    assign step  = ilv ? (start ^ idx) : (start + idx);

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        if (b < LOW_W) begin : g_low
            assign col[b] = lim[b] ? step[b] : base[b];
        end else begin : g_high
            assign col[b] = base[b];
        end
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrs_valid,
    input  logic [BA_W-1:0]   mrs_ba,
    input  logic [WORD_W-1:0] mrs_addr,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ready,
    output logic              beat_valid,
    output logic [COL_W-1:0]  beat_col,
    output logic              beat_last,
    output logic              beat_write,
    output logic              mode_err
);
    logic [2:0]       len_code;
    logic             ilv;
    logic [LOW_W-1:0] idx;
    logic [LOW_W-1:0] lim;
    logic             ilv_q;
    logic [COL_W-1:0] col_q;

    burst_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (mrs_valid),
        .ld_ba    (mrs_ba),
        .ld_word  (mrs_addr),
        .len_code (len_code),
        .ilv      (ilv),
        .bad      (mode_err)
    );

    burst_beat_seq #(.COL_W(COL_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (cmd_valid),
        .req_write (cmd_write),
        .req_col   (cmd_col),
        .len_code  (len_code),
        .ilv       (ilv),
        .ready     (cmd_ready),
        .active    (beat_valid),
        .last      (beat_last),
        .idx       (idx),
        .lim       (lim),
        .ilv_q     (ilv_q),
        .write_q   (beat_write),
        .col_q     (col_q)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base (col_q),
        .idx  (idx),
        .lim  (lim),
        .ilv  (ilv_q),
        .col  (beat_col)
    );
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             mrs_valid,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             beat_valid,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_last,
    input logic             beat_write,
    input logic             mode_err
);
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid); // R3

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> cmd_ready); // R8

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> (beat_valid && !$stable(beat_valid) || beat_valid)); // R8

    AST_BUSY_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> beat_valid); // R8

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> $stable(beat_col[COL_W-1:3])); // R4

    AST_DIR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |=> $stable(beat_write)); // R10

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !mrs_valid |=> $stable(mode_err)); // R6
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mrs_valid  (mrs_valid),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .beat_valid (beat_valid),
    .beat_col   (beat_col),
    .beat_last  (beat_last),
    .beat_write (beat_write),
    .mode_err   (mode_err)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mrs_valid = 1'b0;
    logic [1:0]       mrs_ba = 2'b00;
    logic [12:0]      mrs_addr = '0;
    logic             cmd_valid = 1'b0;
    logic             cmd_write = 1'b0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             cmd_ready;
    logic             beat_valid;
    logic [COL_W-1:0] beat_col;
    logic             beat_last;
    logic             beat_write;
    logic             mode_err;

    always #4 clk = ~clk;   // 125 MHz

    burst_col_gen #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst(rst), .mrs_valid(mrs_valid), .mrs_ba(mrs_ba),
        .mrs_addr(mrs_addr), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_col(cmd_col), .cmd_ready(cmd_ready), .beat_valid(beat_valid),
        .beat_col(beat_col), .beat_last(beat_last), .beat_write(beat_write),
        .mode_err(mode_err)
    );

    int checks = 0;
    int errors = 0;
    string scen = "R1";

    // Reference model: stored word and queue of pending beats {col, last, write}
    int unsigned model_word = 32'h021;
    logic [COL_W+1:0] beats[$];

    function automatic int model_len(int unsigned w);
        case (w & 7)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 2;
        endcase
    endfunction

    function automatic bit model_err(int unsigned w);
        int unsigned l = w & 7;
        int unsigned c = (w >> 4) & 7;
        int unsigned o = (w >> 7) & 63;
        bit ok = ((l >= 1) && (l <= 3)) && ((c == 2) || (c == 6) || (c == 3)) && ((o == 0) || (o == 2));
        return !ok;
    endfunction

    task automatic chk(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, scen, actual, expected, $time);
        end
    endtask

    task automatic push_burst(int unsigned col, bit wr);
        int n = model_len(model_word);
        int unsigned mask = n - 1;
        int unsigned s = col & mask;
        bit ilv = ((model_word >> 3) & 1) != 0;
        for (int i = 0; i < n; i++) begin
            int unsigned low = ilv ? ((s ^ i) & mask) : ((s + i) & mask);
            logic [COL_W-1:0] c = COL_W'((col & ~mask) | low);
            beats.push_back({c, (i == n - 1), wr});
        end
    endtask

    // One clock: compare outputs, drive inputs, advance the model across the edge
    task automatic step(bit mv, logic [1:0] ba, int unsigned w, bit cv, bit wr, int unsigned col);
        bit exp_ready;
        @(negedge clk);
        exp_ready = (beats.size() <= 1);
        chk("R8", cmd_ready, exp_ready);
        chk("R3", beat_valid, beats.size() > 0);
        chk("R6", mode_err, model_err(model_word));
        if (beats.size() > 0) begin
            chk((((model_word >> 3) & 1) != 0) ? "R5" : "R4", beat_col, beats[0][COL_W+1:2]);
            chk("R3", beat_last, beats[0][1]);
            chk("R10", beat_write, beats[0][0]);
        end
        mrs_valid = mv; mrs_ba = ba; mrs_addr = 13'(w);
        cmd_valid = cv; cmd_write = wr; cmd_col = COL_W'(col);
        if (beats.size() > 0) void'(beats.pop_front());
        if (cv && exp_ready) push_burst(col, wr);   // R9: old word used
        if (mv && ba == 2'b00) model_word = w;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 2'b00, 0, 0, 0, 0);
    endtask

    task automatic load(logic [1:0] ba, int unsigned w);
        step(1, ba, w, 0, 0, 0);
    endtask

    task automatic cmd(bit wr, int unsigned col);
        step(0, 2'b00, 0, 1, wr, col);
    endtask

    task automatic drain();
        while (beats.size() > 0) idle(1);
        idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        scen = "R1";
        chk("R1", beat_valid, 0);
        chk("R1", beat_last, 0);
        chk("R1", cmd_ready, 1);
        chk("R1", mode_err, 0);
        idle(2);
        cmd(0, 10'h005); drain();                    // R1 default: 2 beats sequential

        scen = "R2";
        load(2'b01, 13'h02B); load(2'b10, 13'h000); load(2'b11, 13'h007);
        idle(1);
        cmd(1, 10'h10E); drain();                    // still length 2, no error
        load(2'b00, 13'h022); idle(1);               // length 4 sequential
        cmd(0, 10'h0C1); drain();

        scen = "R8";
        for (int s = 0; s < 4; s++) begin            // back-to-back, command on last beat
            cmd(s[0], 10'h200 + s);
            while (beats.size() > 1) cmd(1, 10'h3FF); // ignored while busy
        end
        drain();

        scen = "R4";
        load(2'b00, 13'h023); idle(1);
        for (int s = 0; s < 8; s++) cmd(0, 10'h148 + s);
        drain();
        for (int s = 0; s < 8; s++) begin
            cmd(1, 10'h2F0 + 3 * s);
            while (beats.size() > 1) idle(1);
        end
        drain();

        scen = "R5";
        load(2'b00, 13'h02B); idle(1);
        for (int s = 0; s < 8; s++) begin
            cmd(s[1], 10'h0A0 + s);
            while (beats.size() > 1) idle(1);
        end
        drain();
        load(2'b00, 13'h02A); idle(1);
        for (int s = 0; s < 4; s++) begin
            cmd(0, 10'h333 - s);
            while (beats.size() > 1) idle(1);
        end
        drain();
        load(2'b00, 13'h029); idle(1);
        cmd(0, 10'h011); cmd(1, 10'h010); drain();

        scen = "R6";
        load(2'b00, 13'h063); idle(2);               // latency 2.5 valid
        load(2'b00, 13'h033); idle(2);               // latency 3 valid
        load(2'b00, 13'h013); idle(2);               // reserved latency
        load(2'b00, 13'h123); idle(2);               // DLL reset, valid
        load(2'b00, 13'h0A3); idle(2);               // reserved operating bits
        load(2'b00, 13'h1023); idle(2);

        scen = "R7";
        load(2'b00, 13'h020); idle(1);               // reserved length 000
        cmd(0, 10'h0F7); drain();
        load(2'b00, 13'h02F); idle(1);               // reserved 111, interleaved
        cmd(1, 10'h0F6); drain();
        load(2'b00, 13'h024); idle(1);
        cmd(0, 10'h155); drain();

        scen = "R9";
        load(2'b00, 13'h023); idle(1);
        step(1, 2'b00, 13'h021, 1, 0, 10'h1A3);      // load with accept: still 8 beats
        load(2'b00, 13'h02A);                        // load mid-burst
        while (beats.size() > 1) idle(1);
        cmd(1, 10'h1A6);                             // uses 4-beat interleaved
        step(1, 2'b00, 13'h023, 0, 0, 0);
        drain();
        cmd(0, 10'h07D); drain();

        scen = "R10";
        for (int s = 0; s < 6; s++) cmd(s % 3 == 0, 10'h381 + 5 * s);
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule